// File: doc/BRIEF.md
# Two-Way Set-Associative Load Cache

This block is a read-only data cache placed between a load requester and a pipelined Wishbone memory port. The requester raises `reqValid` with a 64-bit byte address, a non-cacheable flag and byte selects. It keeps these values steady until a clock edge at which `reqStall` is low, and that edge accepts the request. One cycle after acceptance, `rspValid` pulses for a single cycle with the 64-bit doubleword.

The cache is two-way set-associative. It has four sets of 64-byte lines, which is eight doublewords per line, so one way spans 256 bytes of address space. On a cacheable miss the requester is held while the line is refilled in ascending doubleword order. The held load, or any later load to a doubleword of the line that has already arrived, is answered before the refill ends. Loads that hit other resident lines are also answered during a refill.

Non-cacheable loads perform one memory read and leave the cache contents untouched. Stores, translation, snooping and privilege checks are not part of the block.

Top module: `load_cache2w`

## Requirements
- R1: After reset `rspValid`, `wbCyc` and `wbStb` are low, `reqStall` is low while `reqValid` is low, and every line is invalid, so the first cacheable load to any address starts a refill.
- R2: A request is accepted only at a rising edge where `reqValid` is high and `reqStall` is low. `rspValid` is high for exactly the one cycle after each accepting edge and is low otherwise.
- R3: Address bits [5:3] select the doubleword in a line, bits [7:6] select the set, and bits [63:8] are the tag. A cacheable load returns the memory doubleword at the address with bits [2:0] cleared.
- R4: A cacheable miss raises `wbCyc` and issues exactly eight reads. Their addresses are the line base plus 8·k for k = 0..7, in ascending order, with `wbSel` all ones. While `wbStall` is high, `wbStb` and `wbAdr` hold their values.
- R5: During a refill, a load to a doubleword of the refilling line whose acknowledge has already been received is answered while `wbCyc` is still high.
- R6: A load that hits a valid line is answered with no memory read.
- R7: On a miss, an invalid way of the set is filled if one exists, so two different tags at the same set are then both resident.
- R8: When both ways of a set are valid, a miss replaces the way that was not most recently used. A way counts as used when it is hit or when it is chosen for a fill.
- R9: A non-cacheable load issues exactly one read at the request address, with `wbSel` equal to `reqSel`. It returns the acknowledged data and changes no line and no replacement state.
- R10: During a refill, a load that hits a different resident line is answered while `wbCyc` is still high.
- R11: `wbCyc` falls after the eighth acknowledge of a refill, and no bus cycle contains more than eight accepted strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Load request present |
| reqAddr | input | 64 | Load byte address |
| reqNc | input | 1 | Load bypasses the cache |
| reqSel | input | 8 | Byte selects for a non-cacheable read |
| reqStall | output | 1 | Request not accepted at the next edge |
| rspValid | output | 1 | Load data valid (one cycle) |
| rspData | output | 64 | Load data |
| wbCyc | output | 1 | Bus cycle active |
| wbStb | output | 1 | Bus read strobe |
| wbAdr | output | 64 | Bus byte address |
| wbSel | output | 8 | Bus byte selects |
| wbDatIn | input | 64 | Bus read data |
| wbAck | input | 1 | Bus acknowledge |
| wbStall | input | 1 | Bus cannot take a strobe |

## Verification
A wrong tag, valid bit or replacement bit does not show up as wrong data at once. It shows up on a later load to the same set: that load either misses when it should hit, or hits a stale line. The bench therefore keeps its own two-way model per set and compares the number of bus reads of every load with that model, zero, one or eight, as soon as the bus goes idle. A corrupted line word or a misplaced refill beat shows in the response data one cycle after acceptance. A wrong beat counter shows in the refill address order or as a response that arrives only after `wbCyc` has fallen.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int WAYS   = 2;
  localparam int SETS   = 4;
  localparam int BEATS  = 8;
  localparam int BYTE_W = 3;
  localparam int SET_W  = $clog2(SETS);
  localparam int BEAT_W = $clog2(BEATS);
  localparam int IDX_LO = BYTE_W + BEAT_W;

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_NCWAIT, ST_NCDONE} ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              fillWr;
    logic              fillWay;
    logic [SET_W-1:0]  fillSet;
    logic [BEAT_W-1:0] fillBeat;
    logic              rspFire;
    logic              rspNc;
    logic              rdWay;
    logic [SET_W-1:0]  rdSet;
    logic [BEAT_W-1:0] rdBeat;
    logic              ncCap;
  } dpCtl_t;
endpackage

// File: rtl/lc_ctrl.sv
module lc_ctrl import lc_pkg::*; #(
  parameter int ADDR_W = 64,
  parameter int SEL_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqNc,
  input  logic [SEL_W-1:0]  reqSel,
  output logic              reqStall,
  output logic              wbCyc,
  output logic              wbStb,
  output logic [ADDR_W-1:0] wbAdr,
  output logic [SEL_W-1:0]  wbSel,
  input  logic              wbAck,
  input  logic              wbStall,
  output dpCtl_t            dp
);
  localparam int TAG_W = ADDR_W - IDX_LO - SET_W;
  localparam int CNT_W = BEAT_W + 1;

  ctlState_t state;
  logic [TAG_W-1:0] tagMem [WAYS][SETS];
  logic [SETS-1:0]  validW [WAYS];
  logic [SETS-1:0]  lruBit;          // way most recently used per set
  logic             fillWay;
  logic [SET_W-1:0] fillSet;
  logic [TAG_W-1:0] fillTag;
  logic [CNT_W-1:0] issueCnt, ackCnt;
  logic             ncIssued;

  logic [SET_W-1:0]  reqSet;
  logic [BEAT_W-1:0] reqBeat;
  logic [TAG_W-1:0]  reqTag;
  logic [WAYS-1:0]   hitWay;
  logic arrHit, fillHit, canServe, accept, victim, rdWayNext, issueHs, lastAck;

  assign reqBeat = reqAddr[BYTE_W +: BEAT_W];
  assign reqSet  = reqAddr[IDX_LO +: SET_W];
  assign reqTag  = reqAddr[ADDR_W-1 -: TAG_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitWay[w] = validW[w][reqSet] && (tagMem[w][reqSet] == reqTag);
  end

  assign arrHit  = |hitWay;
  assign fillHit = (state == ST_FILL) && (reqSet == fillSet) && (reqTag == fillTag)
                   && ({1'b0, reqBeat} < ackCnt);
  assign rdWayNext = fillHit ? fillWay : hitWay[1];

  always_comb begin
    if (!validW[0][reqSet])      victim = 1'b0;
    else if (!validW[1][reqSet]) victim = 1'b1;
    else                         victim = ~lruBit[reqSet];
  end

  always_comb begin
    case (state)
      ST_IDLE:   canServe = !reqNc && arrHit;
      ST_FILL:   canServe = !reqNc && (arrHit || fillHit);
      ST_NCDONE: canServe = 1'b1;
      default:   canServe = 1'b0;
    endcase
  end

  assign accept   = reqValid && canServe;
  assign reqStall = reqValid && !canServe;

  assign wbCyc = (state == ST_FILL) || (state == ST_NCWAIT);
  assign wbStb = ((state == ST_FILL) && (issueCnt < CNT_W'(BEATS)))
              || ((state == ST_NCWAIT) && !ncIssued);
  assign wbAdr = (state == ST_NCWAIT) ? reqAddr
               : {fillTag, fillSet, issueCnt[BEAT_W-1:0], {BYTE_W{1'b0}}};
  assign wbSel = (state == ST_NCWAIT) ? reqSel : {SEL_W{1'b1}};
  assign issueHs = wbStb && !wbStall;
  assign lastAck = (state == ST_FILL) && wbAck && (ackCnt == CNT_W'(BEATS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      validW   <= '{default: '0};
      lruBit   <= '0;
      fillWay  <= 1'b0;
      fillSet  <= '0;
      fillTag  <= '0;
      issueCnt <= '0;
      ackCnt   <= '0;
      ncIssued <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (reqValid && !canServe) begin
          if (reqNc) begin
            state    <= ST_NCWAIT;
            ncIssued <= 1'b0;
          end else begin
            state                  <= ST_FILL;
            fillWay                <= victim;
            fillSet                <= reqSet;
            fillTag                <= reqTag;
            validW[victim][reqSet] <= 1'b0;
            lruBit[reqSet]         <= victim;
            issueCnt               <= '0;
            ackCnt                 <= '0;
          end
        end
        ST_FILL: begin
          if (issueHs) issueCnt <= issueCnt + 1'b1;
          if (wbAck)   ackCnt   <= ackCnt + 1'b1;
          if (lastAck) begin
            validW[fillWay][fillSet] <= 1'b1;
            tagMem[fillWay][fillSet] <= fillTag;
            state                    <= ST_IDLE;
          end
        end
        ST_NCWAIT: begin
          if (issueHs) ncIssued <= 1'b1;
          if (wbAck)   state    <= ST_NCDONE;
        end
        default: if (accept) state <= ST_IDLE;
      endcase
      if (accept && state != ST_NCDONE) lruBit[reqSet] <= rdWayNext;
    end
  end

  always_comb begin
    dp.fillWr   = (state == ST_FILL) && wbAck;
    dp.fillWay  = fillWay;
    dp.fillSet  = fillSet;
    dp.fillBeat = ackCnt[BEAT_W-1:0];
    dp.rspFire  = accept;
    dp.rspNc    = (state == ST_NCDONE);
    dp.rdWay    = rdWayNext;
    dp.rdSet    = reqSet;
    dp.rdBeat   = reqBeat;
    dp.ncCap    = (state == ST_NCWAIT) && wbAck;
  end
endmodule

// File: rtl/lc_dpath.sv
module lc_dpath import lc_pkg::*; #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtl_t            dp,
  input  logic [DATA_W-1:0] wbDatIn,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);
  logic [DATA_W-1:0] lineMem [WAYS][SETS][BEATS];
  logic [DATA_W-1:0] ncHold;

  always_ff @(posedge clk) begin
    if (dp.fillWr) lineMem[dp.fillWay][dp.fillSet][dp.fillBeat] <= wbDatIn;
    if (dp.ncCap)  ncHold <= wbDatIn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= dp.rspFire;
      if (dp.rspFire)
        rspData <= dp.rspNc ? ncHold : lineMem[dp.rdWay][dp.rdSet][dp.rdBeat];
    end
  end
endmodule

// File: rtl/load_cache2w.sv
module load_cache2w import lc_pkg::*; #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int SEL_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqNc,
  input  logic [SEL_W-1:0]  reqSel,
  output logic              reqStall,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              wbCyc,
  output logic              wbStb,
  output logic [ADDR_W-1:0] wbAdr,
  output logic [SEL_W-1:0]  wbSel,
  input  logic [DATA_W-1:0] wbDatIn,
  input  logic              wbAck,
  input  logic              wbStall
);
  dpCtl_t dpCtl;

  lc_ctrl #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqAddr(reqAddr), .reqNc(reqNc),
    .reqSel(reqSel), .reqStall(reqStall), .wbCyc(wbCyc), .wbStb(wbStb),
    .wbAdr(wbAdr), .wbSel(wbSel), .wbAck(wbAck), .wbStall(wbStall), .dp(dpCtl)
  );

  lc_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rst(rst), .dp(dpCtl), .wbDatIn(wbDatIn),
    .rspValid(rspValid), .rspData(rspData)
  );
endmodule

// File: rtl/lc_chk.sv
module lc_chk import lc_pkg::*; #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              reqStall,
  input logic              rspValid,
  input logic              wbCyc,
  input logic              wbStb,
  input logic              wbStall,
  input logic [ADDR_W-1:0] wbAdr
);
  logic [7:0] strobeCnt;

  always_ff @(posedge clk) begin
    if (rst || !wbCyc)           strobeCnt <= '0;
    else if (wbStb && !wbStall)  strobeCnt <= strobeCnt + 1'b1;
  end

  p_rsp_follows_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !reqStall) |=> rspValid);

  p_rsp_only_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    !(reqValid && !reqStall) |=> !rspValid);

  p_stb_inside_cyc_r4: assert property (@(posedge clk) disable iff (rst)
    wbStb |-> wbCyc);

  p_stb_held_on_stall_r4: assert property (@(posedge clk) disable iff (rst)
    (wbStb && wbStall) |=> (wbStb && $stable(wbAdr)));

  p_strobe_bound_r11: assert property (@(posedge clk) disable iff (rst)
    strobeCnt <= 8'(BEATS));
endmodule

bind load_cache2w lc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqStall(reqStall),
  .rspValid(rspValid), .wbCyc(wbCyc), .wbStb(wbStb), .wbStall(wbStall),
  .wbAdr(wbAdr)
);

// File: tb/load_cache2w_tb.sv
`timescale 1ns/100ps
module load_cache2w_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0, reqNc = 1'b0;
  logic [63:0] reqAddr = '0;
  logic [7:0]  reqSel = 8'hFF;
  logic reqStall, rspValid, wbCyc, wbStb;
  logic [63:0] rspData, wbAdr;
  logic [7:0]  wbSel;
  logic [63:0] wbDatR = '0;
  logic wbAckR = 1'b0, wbStallR = 1'b0;

  int checks = 0, errors = 0, cycles = 0;

  always #2.5 clk = ~clk;

  load_cache2w u_dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqAddr(reqAddr), .reqNc(reqNc),
    .reqSel(reqSel), .reqStall(reqStall), .rspValid(rspValid), .rspData(rspData),
    .wbCyc(wbCyc), .wbStb(wbStb), .wbAdr(wbAdr), .wbSel(wbSel),
    .wbDatIn(wbDatR), .wbAck(wbAckR), .wbStall(wbStallR)
  );

  function automatic logic [63:0] memWord(input logic [63:0] a);
    logic [63:0] d = {a[63:3], 3'b000};
    return (d * 64'h9E3779B97F4A7C15) ^ {d[31:0], d[63:32]};
  endfunction

  // memory slave: pipelined, optional random stall, optional slow acks
  logic [63:0] q [16];
  logic [3:0]  qHead = '0, qTail = '0;
  int          issN = 0;
  logic [63:0] issLog [32];
  logic [7:0]  issSel = '0;
  logic [15:0] lfsr = 16'hACE1;
  logic [1:0]  divCnt = '0;
  bit stallMode = 0, slowMode = 0;

  always @(posedge clk) begin
    if (rst) begin
      qHead <= '0; qTail <= '0; wbAckR <= 1'b0; wbStallR <= 1'b0;
    end else begin
      if (wbCyc && wbStb && !wbStallR) begin
        q[qTail] <= wbAdr;
        qTail <= qTail + 1'b1;
        issLog[issN % 32] <= wbAdr;
        issSel <= wbSel;
        issN <= issN + 1;
      end
      divCnt <= divCnt + 1'b1;
      if (qHead != qTail && (!slowMode || divCnt == 2'd0)) begin
        wbAckR <= 1'b1;
        wbDatR <= memWord(q[qHead]);
        qHead  <= qHead + 1'b1;
      end else wbAckR <= 1'b0;
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wbStallR <= stallMode && lfsr[0];
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // reference model of residency, built from R7 and R8
  bit          mValid [4][2];
  logic [55:0] mTag   [4][2];
  bit          mLru   [4];

  function automatic void modelClear();
    for (int s = 0; s < 4; s++) begin
      mValid[s][0] = 0; mValid[s][1] = 0; mLru[s] = 0;
    end
  endfunction

  function automatic bit modelAccess(input logic [63:0] a);
    int s = int'(a[7:6]);
    logic [55:0] t = a[63:8];
    int v;
    for (int w = 0; w < 2; w++)
      if (mValid[s][w] && mTag[s][w] == t) begin mLru[s] = w[0]; return 1; end
    if (!mValid[s][0]) v = 0;
    else if (!mValid[s][1]) v = 1;
    else v = mLru[s] ? 0 : 1;
    mValid[s][v] = 1; mTag[s][v] = t; mLru[s] = v[0];
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drainBus();
    while (wbCyc) @(negedge clk);
  endtask

  bit lastCyc;

  task automatic doLoad(input logic [63:0] a, input logic nc, input logic [7:0] sel,
                        input bit drain);
    logic [63:0] exp = memWord(a);
    bit hit = 0;
    int n0 = issN;
    if (!nc) hit = modelAccess(a);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqNc = nc; reqSel = sel;
    forever begin
      #1;
      if (!reqStall) break;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    chk(rspValid == 1'b1, "R2 valid after accept", {63'b0, rspValid}, 64'd1);
    chk(rspData == exp, nc ? "R9 nc data" : "R3 load data", rspData, exp);
    lastCyc = wbCyc;
    reqValid = 1'b0;
    @(negedge clk);
    chk(rspValid == 1'b0, "R2 single-cycle valid", {63'b0, rspValid}, 64'd0);
    if (drain) begin
      drainBus();
      if (nc) begin
        chk(issN - n0 == 1, "R9 one nc read", 64'(issN - n0), 64'd1);
        chk(issLog[n0 % 32] == a && issSel == sel, "R9 nc address/sel",
            issLog[n0 % 32], a);
      end else if (hit) begin
        chk(issN == n0, "R6 R7 R8 hit without bus read", 64'(issN - n0), 64'd0);
      end else begin
        chk(issN - n0 == 8, "R1 R7 R8 R11 miss refill count", 64'(issN - n0), 64'd8);
        for (int k = 0; k < 8; k++) begin
          logic [63:0] ea = {a[63:6], 3'(k), 3'b000};
          chk(issLog[(n0 + k) % 32] == ea, "R4 refill order", issLog[(n0 + k) % 32], ea);
        end
      end
    end
  endtask

  function automatic logic [63:0] mkAddr(input int unsigned r);
    logic [55:0] tg;
    case (r % 3)
      0: tg = 56'h0;
      1: tg = 56'h1;
      default: tg = 56'h80_0000_0000_0005;
    endcase
    return {tg, 2'((r >> 4) % 4), 3'((r >> 7) % 8), 3'((r >> 11) % 8)};
  endfunction

  initial begin
    int unsigned rs = 32'h1234_5678;
    modelClear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!rspValid && !wbCyc && !wbStb && !reqStall, "R1 reset outputs",
        {60'b0, rspValid, wbCyc, wbStb, reqStall}, 64'd0);

    // R5: early answers from an in-flight refill (slow acks)
    slowMode = 1;
    doLoad(64'h0000_0000_0000_1004, 1'b0, 8'hFF, 1'b0);
    chk(lastCyc == 1'b1, "R5 held miss answered during refill", {63'b0, lastCyc}, 64'd1);
    doLoad(64'h0000_0000_0000_1028, 1'b0, 8'hFF, 1'b0);
    chk(lastCyc == 1'b1, "R5 arrived beat answered during refill", {63'b0, lastCyc}, 64'd1);
    drainBus();

    // R10: hit to another resident line during a refill
    doLoad(64'h0000_0000_0000_2040, 1'b0, 8'hFF, 1'b0);
    doLoad(64'h0000_0000_0000_1010, 1'b0, 8'hFF, 1'b0);
    chk(lastCyc == 1'b1, "R10 hit served during refill", {63'b0, lastCyc}, 64'd1);
    drainBus();
    slowMode = 0;

    // sweeps over stall / ack-speed combinations
    for (int mode = 0; mode < 4; mode++) begin
      stallMode = mode[0];
      slowMode  = mode[1];
      for (int i = 0; i < 150; i++) begin
        logic nc;
        logic [7:0] sel;
        rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
        nc  = (rs % 11) == 0;
        sel = nc ? (8'(rs >> 20) | 8'h01) : 8'hFF;
        doLoad(mkAddr(rs), nc, sel, 1'b1);
      end
    end
    stallMode = 0; slowMode = 0;

    // R9: nc read of a non-resident line does not allocate it
    doLoad(64'h0000_0000_0000_3088, 1'b1, 8'h0F, 1'b1);
    doLoad(64'h0000_0000_0000_3088, 1'b0, 8'hFF, 1'b1);

    // R1: reset invalidates resident lines
    doLoad(64'h0000_0000_0000_3090, 1'b0, 8'hFF, 1'b1);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    modelClear();
    @(negedge clk);
    chk(!rspValid && !wbCyc && !wbStb, "R1 outputs after second reset",
        {61'b0, rspValid, wbCyc, wbStb}, 64'd0);
    doLoad(64'h0000_0000_0000_3090, 1'b0, 8'hFF, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule